// File: doc/BRIEF.md
# Fault-to-Break Lock Register

This block is a single 32-bit configuration register that decides which system fault signals may trip the emergency-stop (break) input shared by three timers. It watches five fault sources: core lockup, SRAM1 parity error, the programmable voltage detector output, flash ECC double-bit error, and backup SRAM2 parity error. Each source has its own arming bit. Software can set an arming bit but cannot clear it. Only a system reset returns the bits to zero, so a path that has been armed stays armed until the next reset.

The break output is the registered OR of every fault input gated by its arming bit. Arming the voltage-detector path also raises a freeze output. A power-control block uses this output to ignore writes to its detector enable bit and its 3-bit level select field. The register also holds a sticky flag for backup SRAM2 parity errors. The rising edge of that fault input sets the flag, and software clears it by writing 1.

Top module: `fault_brk_lockreg`

## Requirements
- R1: After reset all arming bits and the parity flag are 0, `brk_out` and `pwr_freeze` are 0, and a read of the register returns 0.
- R2: A write to the register address with a 1 in bit position i (0 lockup, 1 SRAM1 parity, 2 voltage detector, 3 ECC, 4 SRAM2 parity) sets arming bit i. A read returns the arming bits in bits 4:0.
- R3: Writing 0 to an armed bit leaves it set. Only reset clears an arming bit.
- R4: `brk_out` equals the OR over i of `fault_in[i]` AND arming bit i, as sampled at the previous clock edge. It changes one cycle after the fault input changes.
- R5: A fault whose arming bit is clear never raises `brk_out`.
- R6: `pwr_freeze` is 1 exactly when arming bit 2 (voltage detector) is set.
- R7: A rising edge on `fault_in[4]` sets the parity flag, which reads back in bit 8, whatever the state of the arming bits. A level that stays high does not set the flag again after it has been cleared.
- R8: Writing 1 to bit 8 clears the parity flag. Writing 0 to bit 8 leaves the flag unchanged.
- R9: When a rising edge on `fault_in[4]` and a write of 1 to bit 8 fall in the same cycle, the flag ends up set.
- R10: Bits 31:9 and 7:5 read as 0 and ignore writes. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Access address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data; 0 unless this register is being read |
| fault_in | input | NSRC (5) | Level fault inputs, synchronous to clk |
| brk_out | output | 1 | Registered break request to the timers |
| pwr_freeze | output | 1 | Write freeze for the detector fields of the power register |

## Verification
The assertions assume that `fault_in` is synchronous to `clk` and stays low while reset is asserted. Under that assumption, an edge seen after reset is a real rising transition. The stimulus changes faults and bus signals only on falling clock edges. It holds faults at 0 around every reset. It sweeps all 32 fault patterns at each arming level, which produces parity-input edges only at known points. The single case where an edge and a clearing write fall in the same cycle is built on purpose.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
   localparam int unsigned SRC_LOCKUP = 0;
   localparam int unsigned SRC_SRAM1  = 1;
   localparam int unsigned SRC_VDET   = 2;
   localparam int unsigned SRC_ECC    = 3;
   localparam int unsigned SRC_SRAM2  = 4;
   localparam int unsigned NUM_SRC    = 5;
   localparam int unsigned FLAG_POS   = 8;
endpackage

// File: rtl/fbl_lock_bank.sv
// Set-only arming bits: software can raise them, only reset drops them.
module fbl_lock_bank #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic [N-1:0] set_mask,
   output logic [N-1:0] lock
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lock[i] <= 1'b0;
         else if (set_stb && set_mask[i])
            lock[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/fbl_sticky_flag.sv
// Edge-captured sticky flag; a hardware set beats a software clear.
module fbl_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_lvl,
   input  logic clr_stb,
   output logic flag
);
   logic prev_q;
   logic rise;

   assign rise = evt_lvl & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag   <= 1'b0;
      end else begin
         prev_q <= evt_lvl;
         if (rise)
            flag <= 1'b1;
         else if (clr_stb)
            flag <= 1'b0;
      end
   end
endmodule

// File: rtl/fbl_break_merge.sv
// Gated OR of the fault sources; REGISTERED selects a flopped or direct output.
module fbl_break_merge #(
   parameter int unsigned N          = 5,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] fault,
   input  logic [N-1:0] arm,
   output logic         brk
);
   logic any_armed;
   assign any_armed = |(fault & arm);

   if (REGISTERED) begin : g_reg
      logic brk_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) brk_q <= 1'b0;
         else        brk_q <= any_armed;
      end
      assign brk = brk_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign brk = any_armed;
   end
endmodule

// File: rtl/fault_brk_lockreg.sv
module fault_brk_lockreg #(
   parameter int unsigned       ADDR_W         = 8,
   parameter int unsigned       DATA_W         = 32,
   parameter logic [ADDR_W-1:0] REG_ADDR       = '0,
   parameter int unsigned       NSRC           = fbl_pkg::NUM_SRC,
   parameter int unsigned       FLAG_BIT       = fbl_pkg::FLAG_POS,
   parameter int unsigned       FREEZE_IDX     = fbl_pkg::SRC_VDET,
   parameter int unsigned       PERR_IDX       = fbl_pkg::SRC_SRAM2,
   parameter bit                BRK_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NSRC-1:0]   fault_in,
   output logic              brk_out,
   output logic              pwr_freeze
);
   if (FLAG_BIT < NSRC || FLAG_BIT >= DATA_W) begin : g_bad_flag
      $error("FLAG_BIT must lie above the arming bits and inside the data word");
   end
   if (FREEZE_IDX >= NSRC || PERR_IDX >= NSRC) begin : g_bad_idx
      $error("FREEZE_IDX and PERR_IDX must name an existing source");
   end
   if (NSRC > DATA_W) begin : g_bad_nsrc
      $error("NSRC must fit in the data word");
   end

   logic            sel;
   logic            wr_hit;
   logic            rd_hit;
   logic [NSRC-1:0] lock_q;
   logic            flag_q;
   logic [DATA_W-1:0] image;
   logic            unused_wdata;

   assign sel          = bus_valid && (bus_addr == REG_ADDR);
   assign wr_hit       = sel && bus_write;
   assign rd_hit       = sel && !bus_write;
   assign unused_wdata = ^bus_wdata;

   fbl_lock_bank #(.N(NSRC)) u_locks (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_stb  (wr_hit),
      .set_mask (bus_wdata[NSRC-1:0]),
      .lock     (lock_q)
   );

   fbl_sticky_flag u_perr_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_lvl (fault_in[PERR_IDX]),
      .clr_stb (wr_hit && bus_wdata[FLAG_BIT]),
      .flag    (flag_q)
   );

   fbl_break_merge #(.N(NSRC), .REGISTERED(BRK_REGISTERED)) u_merge (
      .clk   (clk),
      .rst_n (rst_n),
      .fault (fault_in),
      .arm   (lock_q),
      .brk   (brk_out)
   );

   assign pwr_freeze = lock_q[FREEZE_IDX];

   always_comb begin
      image              = '0;
      image[NSRC-1:0]    = lock_q;
      image[FLAG_BIT]    = flag_q;
   end

   assign bus_rdata = rd_hit ? image : '0;
endmodule

// File: rtl/fbl_checker.sv
module fbl_checker #(
   parameter int unsigned       ADDR_W         = 8,
   parameter int unsigned       DATA_W         = 32,
   parameter logic [ADDR_W-1:0] REG_ADDR       = '0,
   parameter int unsigned       NSRC           = 5,
   parameter int unsigned       FLAG_BIT       = 8,
   parameter int unsigned       FREEZE_IDX     = 2,
   parameter int unsigned       PERR_IDX       = 4,
   parameter bit                BRK_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [NSRC-1:0]   fault_in,
   input logic [NSRC-1:0]   lock,
   input logic              flag,
   input logic              brk_out,
   input logic              pwr_freeze
);
   logic wr_hit;
   logic clr_req;
   assign wr_hit  = bus_valid && bus_write && (bus_addr == REG_ADDR);
   assign clr_req = wr_hit && bus_wdata[FLAG_BIT];

   AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> ((lock & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R2
   AST_LOCK_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(lock) & ~lock) == '0)); // R3

   if (BRK_REGISTERED) begin : g_reg_chk
      AST_BRK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
         (|(fault_in & lock)) |=> brk_out); // R4
      AST_BRK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(fault_in & lock)) |=> !brk_out); // R5
   end else begin : g_comb_chk
      AST_BRK_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
         (|(fault_in & lock)) == brk_out); // R4
   end

   AST_FREEZE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_freeze) |-> $past(wr_hit && bus_wdata[FREEZE_IDX])); // R6
   AST_FLAG_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_in[PERR_IDX]) |=> flag); // R7
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !$rose(fault_in[PERR_IDX])) |=> !flag); // R8
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_req) |=> flag); // R8
   AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && $rose(fault_in[PERR_IDX])) |=> flag); // R9
endmodule

bind fault_brk_lockreg fbl_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .NSRC(NSRC),
   .FLAG_BIT(FLAG_BIT), .FREEZE_IDX(FREEZE_IDX), .PERR_IDX(PERR_IDX),
   .BRK_REGISTERED(BRK_REGISTERED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .fault_in(fault_in),
   .lock(lock_q), .flag(flag_q), .brk_out(brk_out), .pwr_freeze(pwr_freeze)
);

// File: tb/fault_brk_lockreg_test.sv
module fault_brk_lockreg_test;
   localparam int CYC = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        v = 1'b0, w = 1'b0;
   logic [7:0]  a = '0;
   logic [31:0] wd = '0;
   logic [31:0] rd;
   logic [4:0]  f = '0;
   logic        brk, frz;

   int errs = 0;
   int checks = 0;

   logic [4:0] lock_m = '0;
   logic       flag_m = 1'b0;
   logic       fprev_m = 1'b0;
   logic       brk_m = 1'b0;

   always #(CYC/2) clk = ~clk;

   fault_brk_lockreg uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(v), .bus_write(w), .bus_addr(a),
      .bus_wdata(wd), .bus_rdata(rd), .fault_in(f), .brk_out(brk), .pwr_freeze(frz)
   );

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] img();
      logic [31:0] r = 32'(lock_m);
      r[8] = flag_m;
      return r;
   endfunction

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; f = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      lock_m = '0; flag_m = 1'b0; fprev_m = 1'b0; brk_m = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] ad, input logic [31:0] exp, input string tag);
      @(negedge clk); v = 1'b1; w = 1'b0; a = ad;
      #1 check(tag, "readback", rd, exp);
      v = 1'b0; a = '0;
   endtask

   task automatic wr(input logic [7:0] ad, input logic [31:0] d);
      @(negedge clk); v = 1'b1; w = 1'b1; a = ad; wd = d;
      @(negedge clk); v = 1'b0; w = 1'b0; a = '0; wd = '0;
      if (ad == 8'h00) begin
         lock_m |= d[4:0];
         if (d[8]) flag_m = 1'b0;
      end
      brk_m = |(f & lock_m);
   endtask

   // checks the break from the previous pattern, then applies a new one
   task automatic drive(input logic [4:0] val);
      @(negedge clk);
      check("R4/R5", "brk_out", 32'(brk), 32'(brk_m));
      f = val;
      if (val[4] && !fprev_m) flag_m = 1'b1;
      fprev_m = val[4];
      brk_m = |(val & lock_m);
   endtask

   initial begin
      #(CYC * 150000);
      errs++;
      $display("FAIL watchdog R1 run did not finish");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
   end

   initial begin
      do_reset();
      // R1: reset state
      @(negedge clk);
      check("R1", "brk_out", 32'(brk), 32'd0);
      check("R1", "pwr_freeze", 32'(frz), 32'd0);
      rd_chk(8'h00, 32'h0, "R1");

      // R10: another address is ignored
      wr(8'h04, 32'hFFFF_FFFF);
      rd_chk(8'h00, 32'h0, "R10");
      rd_chk(8'h04, 32'h0, "R10");

      // Pass 1: arm one source per step, sweeping every fault pattern
      for (int k = 0; k <= 5; k++) begin
         for (int p = 0; p < 32; p++) drive(5'(p));
         drive(5'h00);
         drive(5'h00);
         check("R6", "pwr_freeze", 32'(frz), 32'(lock_m[2]));
         rd_chk(8'h00, img(), "R7");
         wr(8'h00, 32'hFFFF_FE00);          // unused bits set, flag bit 0
         rd_chk(8'h00, img(), "R8");
         rd_chk(8'h00, img(), "R10");
         wr(8'h00, 32'h0000_0100);
         rd_chk(8'h00, img(), "R8");
         if (k < 5) begin
            wr(8'h00, 32'(1) << k);
            rd_chk(8'h00, img(), "R2");
            wr(8'h00, 32'h0);
            rd_chk(8'h00, img(), "R3");
            @(negedge clk);
            check("R6", "pwr_freeze", 32'(frz), 32'(lock_m[2]));
         end
      end

      // R3: only reset disarms
      drive(5'h00);
      do_reset();
      @(negedge clk);
      check("R3", "pwr_freeze after reset", 32'(frz), 32'd0);
      rd_chk(8'h00, 32'h0, "R1");

      // Pass 2: two sources armed together
      wr(8'h00, 32'h0000_0014);
      rd_chk(8'h00, img(), "R2");
      @(negedge clk);
      check("R6", "pwr_freeze", 32'(frz), 32'd1);
      for (int p = 0; p < 32; p++) drive(5'(p));
      drive(5'h00);
      drive(5'h00);
      rd_chk(8'h00, img(), "R7");

      // R9: rising edge and clearing write in the same cycle
      wr(8'h00, 32'h0000_0100);
      rd_chk(8'h00, img(), "R8");
      drive(5'h00);
      @(negedge clk);
      check("R4/R5", "brk_out", 32'(brk), 32'(brk_m));
      f = 5'h10; v = 1'b1; w = 1'b1; a = 8'h00; wd = 32'h0000_0100;
      @(negedge clk); v = 1'b0; w = 1'b0; wd = '0;
      flag_m = 1'b1; fprev_m = 1'b1; brk_m = 1'b1;
      rd_chk(8'h00, img(), "R9");

      // R7: a held level does not set the flag again
      wr(8'h00, 32'h0000_0100);
      repeat (3) @(negedge clk);
      rd_chk(8'h00, img(), "R7");
      check("R7", "flag stays clear", 32'(rd[8]), 32'd0);
      drive(5'h00);
      drive(5'h00);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule